// File: doc/BRIEF.md
# Serial Clock-Synthesizer Parameter Loader

This block sits between a register-write port and a programmable clock synthesizer. Software cannot write the synthesizer settings as one word. It sends them one bit per write. Bit 0 of each written value is the serial data bit, and bit 1 is a load flag. The loader finds the start of a frame from a resynchronizing preamble and shifts the frame bits into a shadow word. When the load flag arrives on the last bit of a frame of the correct length, it copies the fields to its parallel outputs in a single step.

Each frame holds five fields:
- an output post-divider select (0 = divide by 1, 1 = divide by 2, 2 = divide by 4);
- a frequency range code (00 = up to 120 MHz, 01 = up to 200 MHz, 10 = above 200 MHz);
- three 8-bit divider values, called M, A and R.

Filler bits and fixed control bits between the fields are shifted through but not brought out. A committed M value above 63 raises a status bit. A load flag that arrives at the wrong point is ignored and produces a one-cycle error pulse. Software searches for the divider values. The analog loop itself lies outside this block.

Top module: `clk_synth_loader`

## Requirements
- R1: After reset, all parameter outputs, `updPulse`, `badLoad` and `mErr` are 0.
- R2: A write (`wrEn` high) carries its serial bit in `wrData[0]`. A frame starts only after a preamble of a 1 followed by exactly eleven 0s. Zeros written while waiting for the preamble are ignored. A 1 written during the preamble restarts the preamble count.
- R3: Frame bits arrive in this order: post-divider select (2 bits), 10 filler bits, range code (2 bits), 6 control bits, M (8 bits), A (8 bits), R (8 bits). Every field is sent least-significant bit first. The committed outputs equal these field values.
- R4: A write with `wrData[1]` set, made as the 44th frame bit, commits all fields. The new outputs and a single-cycle `updPulse` appear in the cycle after that write.
- R5: A load flag sent inside a frame at any bit count other than 44 (fewer bits, or more than 44) commits nothing. It raises `badLoad` for one cycle after the write, and the loader goes back to waiting for a preamble.
- R6: Committed outputs keep their values while a later frame is being shifted in, and change only when that frame commits.
- R7: `mErr` is set by a commit whose M exceeds 63, and cleared by a commit whose M is 63 or less.
- R8: A load flag written while the loader is waiting for a preamble, or partway through one, commits nothing and raises `badLoad` for one cycle.
- R9: Cycles with `wrEn` low have no effect on the frame being received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe |
| wrData | input | 2 | Bit 0: serial data bit; bit 1: load flag |
| postSel | output | 2 | Committed post-divider select |
| rangeCode | output | 2 | Committed frequency range code |
| mDiv | output | 8 | Committed M divider |
| aDiv | output | 8 | Committed A divider |
| rDiv | output | 8 | Committed R divider |
| updPulse | output | 1 | One-cycle pulse after a commit |
| badLoad | output | 1 | One-cycle pulse after a misplaced load flag |
| mErr | output | 1 | Committed M exceeds 63 |

## Verification
The embedded assertions check the following on every cycle:
- the parameter outputs change only in a cycle where `updPulse` is high;
- `updPulse` never lasts two cycles;
- `updPulse` and `badLoad` are never high together;
- the loader returns to waiting for a preamble after any load flag;
- the frame bit counter starts at zero and stays within its bound;
- `mErr` matches the committed M value.

Only the directed scenarios can show the rest: that each field lands in the right bit positions, that a preamble interrupted by a 1 or one zero too short either realigns or fails the frame, and that a flag at 43 or 45 bits is rejected while the old values stay in place.

// File: rtl/clk_synth_pkg.sv
package clk_synth_pkg;

  typedef struct packed {
    logic shiftEn;
    logic commit;
  } ldCtl_t;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_PRE   = 2'd1,
    ST_FRAME = 2'd2
  } ldState_t;

endpackage

// File: rtl/clk_synth_ctrl.sv
module clk_synth_ctrl
  import clk_synth_pkg::*;
#(
  parameter int FRAME_LEN = 44,
  parameter int PRE_LEN   = 12
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   wrEn,
  input  logic   bitIn,
  input  logic   loadFlag,
  output ldCtl_t ctl,
  output logic   badLoad
);

  localparam int CNT_W = $clog2(FRAME_LEN + 1);
  localparam int PRE_W = $clog2(PRE_LEN);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_LEN);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_LEN - 2);

  ldState_t          state, stateNxt;
  logic [CNT_W-1:0]  bitCnt, bitCntNxt;
  logic [PRE_W-1:0]  preCnt, preCntNxt;
  logic              badNxt;

  always_comb begin
    stateNxt  = state;
    bitCntNxt = bitCnt;
    preCntNxt = preCnt;
    badNxt    = 1'b0;
    ctl       = '0;
    if (wrEn) begin
      unique case (state)
        ST_HUNT: begin
          if (loadFlag) begin
            badNxt = 1'b1;
          end else if (bitIn) begin
            stateNxt  = ST_PRE;
            preCntNxt = '0;
          end
        end
        ST_PRE: begin
          if (loadFlag) begin
            badNxt   = 1'b1;
            stateNxt = ST_HUNT;
          end else if (bitIn) begin
            preCntNxt = '0;
          end else if (preCnt == PRE_LAST) begin
            stateNxt  = ST_FRAME;
            bitCntNxt = '0;
          end else begin
            preCntNxt = preCnt + 1'b1;
          end
        end
        ST_FRAME: begin
          ctl.shiftEn = 1'b1;
          if (loadFlag) begin
            stateNxt = ST_HUNT;
            if (bitCnt == LAST_BIT) ctl.commit = 1'b1;
            else                    badNxt     = 1'b1;
          end else if (bitCnt != CNT_SAT) begin
            bitCntNxt = bitCnt + 1'b1;
          end
        end
        default: stateNxt = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_HUNT;
      bitCnt  <= '0;
      preCnt  <= '0;
      badLoad <= 1'b0;
    end else begin
      state   <= stateNxt;
      bitCnt  <= bitCntNxt;
      preCnt  <= preCntNxt;
      badLoad <= badNxt;
    end
  end

  AST_FLAG_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && loadFlag) |=> (state == ST_HUNT)); // R5

  AST_FRAME_START_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_FRAME) |-> (bitCnt == '0)); // R2

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_SAT); // R4

endmodule

// File: rtl/clk_synth_dpath.sv
module clk_synth_dpath
  import clk_synth_pkg::*;
#(
  parameter int POST_W  = 2,
  parameter int FILL_W  = 10,
  parameter int RANGE_W = 2,
  parameter int CTRL_W  = 6,
  parameter int DIV_W   = 8,
  parameter int M_MAX   = 63
) (
  input  logic               clk,
  input  logic               rstN,
  input  ldCtl_t             ctl,
  input  logic               bitIn,
  output logic [POST_W-1:0]  postSel,
  output logic [RANGE_W-1:0] rangeCode,
  output logic [DIV_W-1:0]   mDiv,
  output logic [DIV_W-1:0]   aDiv,
  output logic [DIV_W-1:0]   rDiv,
  output logic               updPulse,
  output logic               mErr
);

  localparam int FRAME_LEN = POST_W + FILL_W + RANGE_W + CTRL_W + 3 * DIV_W;
  localparam int SH_W      = FRAME_LEN - 1;
  localparam int RANGE_LO  = POST_W + FILL_W;
  localparam int M_LO      = RANGE_LO + RANGE_W + CTRL_W;
  localparam int A_LO      = M_LO + DIV_W;
  localparam int R_LO      = A_LO + DIV_W;
  localparam logic [DIV_W-1:0] M_LIMIT = DIV_W'(M_MAX);

  logic [SH_W-1:0]  shadow;
  logic [DIV_W-1:0] mNew;

  assign mNew = shadow[M_LO +: DIV_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shadow <= '0;
    else if (ctl.shiftEn) shadow <= {bitIn, shadow[SH_W-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      postSel   <= '0;
      rangeCode <= '0;
      mDiv      <= '0;
      aDiv      <= '0;
      rDiv      <= '0;
      mErr      <= 1'b0;
      updPulse  <= 1'b0;
    end else begin
      updPulse <= ctl.commit;
      if (ctl.commit) begin
        postSel   <= shadow[0 +: POST_W];
        rangeCode <= shadow[RANGE_LO +: RANGE_W];
        mDiv      <= mNew;
        aDiv      <= shadow[A_LO +: DIV_W];
        rDiv      <= {bitIn, shadow[R_LO +: DIV_W-1]};
        mErr      <= (mNew > M_LIMIT);
      end
    end
  end

  AST_HOLD_UNLESS_UPD: assert property (@(posedge clk) disable iff (!rstN)
    !updPulse |-> ($stable(mDiv) && $stable(aDiv) && $stable(rDiv)
                   && $stable(postSel) && $stable(rangeCode))); // R6

  AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    updPulse |=> !updPulse); // R4

  AST_MERR_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    updPulse |-> (mErr == (mDiv > M_LIMIT))); // R7

endmodule

// File: rtl/clk_synth_loader.sv
module clk_synth_loader
  import clk_synth_pkg::*;
#(
  parameter int POST_W  = 2,
  parameter int FILL_W  = 10,
  parameter int RANGE_W = 2,
  parameter int CTRL_W  = 6,
  parameter int DIV_W   = 8,
  parameter int PRE_LEN = 12,
  parameter int M_MAX   = 63
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         wrData,
  output logic [POST_W-1:0]  postSel,
  output logic [RANGE_W-1:0] rangeCode,
  output logic [DIV_W-1:0]   mDiv,
  output logic [DIV_W-1:0]   aDiv,
  output logic [DIV_W-1:0]   rDiv,
  output logic               updPulse,
  output logic               badLoad,
  output logic               mErr
);

  localparam int FRAME_LEN = POST_W + FILL_W + RANGE_W + CTRL_W + 3 * DIV_W;

  ldCtl_t ctl;

  clk_synth_ctrl #(
    .FRAME_LEN(FRAME_LEN),
    .PRE_LEN  (PRE_LEN)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .bitIn   (wrData[0]),
    .loadFlag(wrData[1]),
    .ctl     (ctl),
    .badLoad (badLoad)
  );

  clk_synth_dpath #(
    .POST_W (POST_W),
    .FILL_W (FILL_W),
    .RANGE_W(RANGE_W),
    .CTRL_W (CTRL_W),
    .DIV_W  (DIV_W),
    .M_MAX  (M_MAX)
  ) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .bitIn    (wrData[0]),
    .postSel  (postSel),
    .rangeCode(rangeCode),
    .mDiv     (mDiv),
    .aDiv     (aDiv),
    .rDiv     (rDiv),
    .updPulse (updPulse),
    .mErr     (mErr)
  );

  AST_NO_DUAL_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    !(updPulse && badLoad)); // R5

endmodule

// File: tb/tb_clk_synth_loader.sv
module tb_clk_synth_loader;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrData = 2'b00;
  logic [1:0] postSel, rangeCode;
  logic [7:0] mDiv, aDiv, rDiv;
  logic       updPulse, badLoad, mErr;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  logic [1:0] ePost = 0, eRange = 0;
  logic [7:0] eM = 0, eA = 0, eR = 0;
  logic       eMErr = 0;

  always #2.5 clk = ~clk;

  clk_synth_loader dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .postSel(postSel), .rangeCode(rangeCode), .mDiv(mDiv), .aDiv(aDiv),
    .rDiv(rDiv), .updPulse(updPulse), .badLoad(badLoad), .mErr(mErr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic b, input logic f);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = {f, b};
    @(negedge clk);
    wrEn = 1'b0;
    wrData = 2'b00;
  endtask

  task automatic preamble();
    wr(1'b1, 1'b0);
    repeat (11) wr(1'b0, 1'b0);
  endtask

  function automatic logic [43:0] mkFrame(input logic [1:0] p, input logic [1:0] rg,
                                          input logic [7:0] m, input logic [7:0] a,
                                          input logic [7:0] r);
    return {r, a, m, 6'b100101, rg, 10'b0, p};
  endfunction

  task automatic frameBits(input logic [43:0] fr, input int nBits, input bit flagLast);
    for (int i = 0; i < nBits; i++) wr(fr[i], flagLast && (i == nBits - 1));
  endtask

  task automatic chkOutputs(input string req);
    chk({req, " postSel"}, postSel, ePost);
    chk({req, " rangeCode"}, rangeCode, eRange);
    chk({req, " mDiv"}, mDiv, eM);
    chk({req, " aDiv"}, aDiv, eA);
    chk({req, " rDiv"}, rDiv, eR);
    chk({req, " mErr"}, mErr, eMErr);
  endtask

  task automatic goodFrame(input string req, input logic [1:0] p, input logic [1:0] rg,
                           input logic [7:0] m, input logic [7:0] a, input logic [7:0] r);
    preamble();
    frameBits(mkFrame(p, rg, m, a, r), 44, 1'b1);
    ePost = p; eRange = rg; eM = m; eA = a; eR = r; eMErr = (m > 8'd63);
    chk({req, " R4 updPulse"}, updPulse, 1);
    chk({req, " R5 badLoad"}, badLoad, 0);
    chkOutputs(req);
    @(negedge clk);
    chk({req, " R4 pulse width"}, updPulse, 0);
  endtask

  task automatic tReset();
    chkOutputs("R1 reset");
    chk("R1 updPulse", updPulse, 0);
    chk("R1 badLoad", badLoad, 0);
  endtask

  task automatic tBasic();
    goodFrame("R3 basic", 2'd2, 2'b01, 8'd34, 8'd1, 8'd29);
    goodFrame("R3 pattern", 2'd1, 2'b10, 8'h3F, 8'hA5, 8'hC3);
    goodFrame("R3 zero", 2'd0, 2'b00, 8'h00, 8'h00, 8'h80);
  endtask

  task automatic tHoldAndShort();
    logic [43:0] fr;
    fr = mkFrame(2'd0, 2'b11, 8'h11, 8'h22, 8'h33);
    preamble();
    frameBits(fr, 20, 1'b0);
    chkOutputs("R6 hold mid-frame");
    wr(fr[20], 1'b1);
    chk("R5 short flag badLoad", badLoad, 1);
    chk("R5 short flag no update", updPulse, 0);
    chkOutputs("R5 short frame");
    @(negedge clk);
    chk("R5 badLoad width", badLoad, 0);
    preamble();
    frameBits(fr, 43, 1'b1);
    chk("R5 43-bit badLoad", badLoad, 1);
    chkOutputs("R5 43-bit frame");
    preamble();
    frameBits(fr, 44, 1'b0);
    wr(1'b0, 1'b1);
    chk("R5 45-bit badLoad", badLoad, 1);
    chk("R5 45-bit no update", updPulse, 0);
    chkOutputs("R5 45-bit frame");
  endtask

  task automatic tMErr();
    goodFrame("R7 M=200", 2'd0, 2'b00, 8'd200, 8'd3, 8'd4);
    chk("R7 mErr set", mErr, 1);
    goodFrame("R7 M=64", 2'd1, 2'b01, 8'd64, 8'd3, 8'd4);
    chk("R7 mErr at 64", mErr, 1);
    goodFrame("R7 M=63", 2'd1, 2'b01, 8'd63, 8'd3, 8'd4);
    chk("R7 mErr cleared", mErr, 0);
  endtask

  task automatic tOutside();
    wr(1'b0, 1'b1);
    chk("R8 flag while hunting badLoad", badLoad, 1);
    chk("R8 flag while hunting no update", updPulse, 0);
    wr(1'b1, 1'b0);
    repeat (5) wr(1'b0, 1'b0);
    wr(1'b0, 1'b1);
    chk("R8 flag in preamble badLoad", badLoad, 1);
    chkOutputs("R8 flag in preamble");
  endtask

  task automatic tResync();
    repeat (3) wr(1'b0, 1'b0);
    wr(1'b1, 1'b0);
    repeat (4) wr(1'b0, 1'b0);
    goodFrame("R2 restart preamble", 2'd2, 2'b10, 8'h2A, 8'h5C, 8'h0F);
    wr(1'b1, 1'b0);
    repeat (10) wr(1'b0, 1'b0);
    frameBits(mkFrame(2'd1, 2'b01, 8'h01, 8'h02, 8'h03), 44, 1'b1);
    chk("R2 short preamble rejected", badLoad, 1);
    chk("R2 short preamble no update", updPulse, 0);
    chkOutputs("R2 short preamble");
  endtask

  task automatic tIdleCycles();
    logic [43:0] fr;
    fr = mkFrame(2'd1, 2'b10, 8'h07, 8'hE1, 8'h9B);
    preamble();
    for (int i = 0; i < 44; i++) begin
      if (i % 7 == 3) begin
        @(negedge clk);
        wrEn = 1'b0;
        wrData = 2'b11;
        @(negedge clk);
        wrData = 2'b00;
      end
      wr(fr[i], i == 43);
    end
    ePost = 2'd1; eRange = 2'b10; eM = 8'h07; eA = 8'hE1; eR = 8'h9B; eMErr = 0;
    chk("R9 idle cycles ignored updPulse", updPulse, 1);
    chkOutputs("R9 idle cycles");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tBasic();
    tHoldAndShort();
    tMErr();
    tOutside();
    tResync();
    tIdleCycles();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule